// File: doc/BRIEF.md
# Sweep Gating Controller

This block decides when a main time-base sweep starts and when it stops. A digital ramp counter stands in for the sweep. While the block is waiting, it watches a one-cycle trigger input. A mode input selects one of three starting rules. Normal mode starts only on a trigger. Auto mode also starts on its own after a stretch of cycles with no trigger. Single mode starts one sweep each time an arm pulse is given.

Each sweep lasts a programmable number of clock cycles. A programmable hold-off interval always follows the sweep, and no new sweep can start during it. A trigger that arrives while a sweep or a hold-off is in progress is dropped and is not saved for later. The outputs are a ramp-run enable, a gate that is high exactly during the sweep, the current ramp position, a one-cycle end-of-sweep strobe, and a not-triggered flag for a display.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first sweep, gate_o, ramp_run_o and sweep_end_o are 0, ramp_pos_o is 0 and not_trig_o is 1.
- R2: In normal mode, when trig_i is 1 in a waiting cycle, the sweep starts at that clock edge. With no trigger, no sweep ever starts.
- R3: In auto mode, a waiting period of AUTO_WAIT cycles with no trigger starts a sweep by itself. A trigger during the wait starts the sweep at once.
- R4: In single mode, a trigger starts a sweep only if an arm_i pulse has been seen since the last single sweep started. Starting the sweep clears the armed state, and reset also leaves it cleared.
- R5: gate_o and ramp_run_o are high for exactly L cycles per sweep, where L is sweep_len_i captured at the start, and a value of 0 counts as 1. During those cycles ramp_pos_o counts 0, 1, ..., L-1.
- R6: sweep_end_o is high for one cycle only, and that cycle is the last cycle of the sweep.
- R7: After each sweep, the block spends H hold-off cycles before it waits again. H is holdoff_len_i captured on the last sweep cycle, and a value of 0 counts as 1. With a trigger held high, the gate is therefore low for H+1 cycles between sweeps.
- R8: A trigger during a sweep or during hold-off has no effect, and it does not start a sweep later.
- R9: not_trig_o is cleared when a sweep starts from a trigger. It is set when AUTO_WAIT waiting cycles pass with no trigger, in any mode.
- R10: The mode_i encoding is 2'b00 auto, 2'b01 normal and 2'b10 single. The value 2'b11 behaves as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Trigger mode select |
| trig_i | input | 1 | Trigger pulse, one event per high cycle |
| arm_i | input | 1 | Arm pulse for single mode |
| holdoff_len_i | input | CNT_W | Hold-off length in cycles |
| sweep_len_i | input | CNT_W | Sweep length in cycles |
| ramp_run_o | output | 1 | Ramp counter enable |
| gate_o | output | 1 | High during the sweep |
| not_trig_o | output | 1 | Sweep not being triggered |
| sweep_end_o | output | 1 | One-cycle strobe on the last sweep cycle |
| ramp_pos_o | output | CNT_W | Current ramp position |

## Verification
A trigger that is present at a clock edge in a waiting cycle raises the gate right after that edge, so the bench drives the trigger at a falling edge and expects the gate high at the next falling edge. The gate and the ramp position change on the same edge, and so does not_trig_o when it changes at a start. Widths and gaps are measured by counting samples taken at falling edges. A sweep is expected to give L high samples. The gap is expected to be H+1 low samples when a trigger is held high, and H+AUTO_WAIT low samples in auto mode with no trigger. Ignored triggers and unarmed single starts are checked by watching the gate stay low through a window that is longer than any legal wait.

// File: rtl/sweep_gate_pkg.sv
package sweep_gate_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_HOLD  = 2'd2
  } sg_state_e;

  localparam logic [1:0] MODE_AUTO   = 2'b00;
  localparam logic [1:0] MODE_NORMAL = 2'b01;
  localparam logic [1:0] MODE_SINGLE = 2'b10;

endpackage

// File: rtl/sweep_ramp_cnt.sv
// Ramp position counter. The length is latched when the sweep starts.
module sweep_ramp_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             at_lim;

  assign lim_d  = (len_i == '0) ? '0 : len_i - ONE;
  assign at_lim = (pos_q == lim_q);
  assign last_o = run_i && at_lim;
  assign pos_o  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      pos_q <= '0;
      lim_q <= lim_d;
    end else if (run_i && !at_lim) begin
      pos_q <= pos_q + ONE;
    end
  end

endmodule

// File: rtl/sweep_holdoff_tmr.sv
// Hold-off interval timer. The length is latched on the last sweep cycle.
module sweep_holdoff_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             at_lim;

  assign lim_d  = (len_i == '0) ? '0 : len_i - ONE;
  assign at_lim = (cnt_q == lim_q);
  assign done_o = run_i && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= lim_d;
    end else if (run_i && !at_lim) begin
      cnt_q <= cnt_q + ONE;
    end
  end

endmodule

// File: rtl/sweep_auto_tmr.sv
// Counts waiting cycles with no trigger. It clears whenever it is not running.
module sweep_auto_tmr #(
  parameter int AUTO_WAIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int            AW  = $clog2(AUTO_WAIT + 1);
  localparam logic [AW-1:0] LIM = AW'(AUTO_WAIT - 1);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          at_lim;

  assign at_lim   = (cnt_q == LIM);
  assign expire_o = run_i && at_lim;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || at_lim) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sweep_gate_fsm.sv
// Wait / sweep / hold-off sequencer with mode rules, arming and the trigger flag.
module sweep_gate_fsm
  import sweep_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       trig_i,
  input  logic       arm_i,
  input  logic       ramp_last_i,
  input  logic       hold_done_i,
  input  logic       auto_expire_i,
  output sg_state_e  state_o,
  output logic       start_o,
  output logic       not_trig_o
);

  sg_state_e state_q, state_d;
  logic      armed_q, armed_d;
  logic      ntrig_q, ntrig_d;
  logic      is_auto, is_single, waiting;
  logic      trig_start, auto_start;

  assign is_auto    = (mode_i == MODE_AUTO);
  assign is_single  = (mode_i == MODE_SINGLE);
  assign waiting    = (state_q == ST_WAIT);
  assign trig_start = waiting && trig_i && (!is_single || armed_q);
  assign auto_start = waiting && is_auto && auto_expire_i;
  assign start_o    = trig_start || auto_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT:  if (start_o)     state_d = ST_SWEEP;
      ST_SWEEP: if (ramp_last_i) state_d = ST_HOLD;
      ST_HOLD:  if (hold_done_i) state_d = ST_WAIT;
      default:                   state_d = ST_WAIT;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    if (start_o && is_single) begin
      armed_d = 1'b0;
    end else if (arm_i) begin
      armed_d = 1'b1;
    end
  end

  always_comb begin
    ntrig_d = ntrig_q;
    if (trig_start) begin
      ntrig_d = 1'b0;
    end else if (auto_expire_i) begin
      ntrig_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      armed_q <= 1'b0;
      ntrig_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      ntrig_q <= ntrig_d;
    end
  end

  assign state_o    = state_q;
  assign not_trig_o = ntrig_q;

endmodule

// File: rtl/sweep_gate_ctrl.sv
module sweep_gate_ctrl
  import sweep_gate_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int AUTO_WAIT = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             trig_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] holdoff_len_i,
  input  logic [CNT_W-1:0] sweep_len_i,
  output logic             ramp_run_o,
  output logic             gate_o,
  output logic             not_trig_o,
  output logic             sweep_end_o,
  output logic [CNT_W-1:0] ramp_pos_o
);

  // Reset: asserted asynchronously, released on the clock after two stages.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  sg_state_e state;
  logic      start;
  logic      ramp_last;
  logic      hold_done;
  logic      auto_expire;
  logic      in_sweep;
  logic      in_hold;
  logic      auto_run;

  assign in_sweep = (state == ST_SWEEP);
  assign in_hold  = (state == ST_HOLD);
  assign auto_run = (state == ST_WAIT) && !trig_i;

  sweep_gate_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .mode_i        (mode_i),
    .trig_i        (trig_i),
    .arm_i         (arm_i),
    .ramp_last_i   (ramp_last),
    .hold_done_i   (hold_done),
    .auto_expire_i (auto_expire),
    .state_o       (state),
    .start_o       (start),
    .not_trig_o    (not_trig_o)
  );

  sweep_ramp_cnt #(.CNT_W(CNT_W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (start),
    .run_i  (in_sweep),
    .len_i  (sweep_len_i),
    .pos_o  (ramp_pos_o),
    .last_o (ramp_last)
  );

  sweep_holdoff_tmr #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (ramp_last),
    .run_i  (in_hold),
    .len_i  (holdoff_len_i),
    .done_o (hold_done)
  );

  sweep_auto_tmr #(.AUTO_WAIT(AUTO_WAIT)) u_auto (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run_i    (auto_run),
    .expire_o (auto_expire)
  );

  assign ramp_run_o  = in_sweep;
  assign gate_o      = in_sweep;
  assign sweep_end_o = ramp_last;

endmodule

// File: rtl/sweep_gate_chk.sv
module sweep_gate_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_o,
  input logic             sweep_end_o,
  input logic             not_trig_o,
  input logic [CNT_W-1:0] ramp_pos_o
);

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !sweep_end_o) |=> gate_o);

  // R5
  ramp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (ramp_pos_o == '0));

  // R5
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !sweep_end_o) |=> (ramp_pos_o == $past(ramp_pos_o) + 1'b1));

  // R6
  end_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end_o |-> gate_o);

  // R6
  end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end_o |=> (!sweep_end_o && !gate_o));

  // R7
  holdoff_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |=> !gate_o);

  // R9
  ntrig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_trig_o) |-> $rose(gate_o));

endmodule

bind sweep_gate_ctrl sweep_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .gate_o      (gate_o),
  .sweep_end_o (sweep_end_o),
  .not_trig_o  (not_trig_o),
  .ramp_pos_o  (ramp_pos_o)
);

// File: tb/sweep_gate_ctrl_tb.sv
module sweep_gate_ctrl_tb;

  localparam int CNT_W = 8;
  localparam int AW    = 20;
  localparam int NVEC  = 6;

  // {mode, sweep length, hold-off length}
  localparam logic [17:0] VEC [0:NVEC-1] = '{
    {2'b01, 8'd4,  8'd3},
    {2'b01, 8'd1,  8'd1},
    {2'b00, 8'd7,  8'd2},
    {2'b01, 8'd3,  8'd0},
    {2'b00, 8'd0,  8'd5},
    {2'b11, 8'd10, 8'd4}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode_i;
  logic             trig_i;
  logic             arm_i;
  logic [CNT_W-1:0] holdoff_len_i;
  logic [CNT_W-1:0] sweep_len_i;
  logic             ramp_run_o;
  logic             gate_o;
  logic             not_trig_o;
  logic             sweep_end_o;
  logic [CNT_W-1:0] ramp_pos_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sweep_gate_ctrl #(.CNT_W(CNT_W), .AUTO_WAIT(AW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .trig_i        (trig_i),
    .arm_i         (arm_i),
    .holdoff_len_i (holdoff_len_i),
    .sweep_len_i   (sweep_len_i),
    .ramp_run_o    (ramp_run_o),
    .gate_o        (gate_o),
    .not_trig_o    (not_trig_o),
    .sweep_end_o   (sweep_end_o),
    .ramp_pos_o    (ramp_pos_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts samples while gate_o equals lvl; stops on the first other sample.
  task automatic run_len(input logic lvl, output int n, output int ends, output bit pos_bad);
    n = 0; ends = 0; pos_bad = 1'b0;
    while (gate_o === lvl && n < 300) begin
      if (sweep_end_o) ends++;
      if (lvl && ramp_pos_o != CNT_W'(n)) pos_bad = 1'b1;
      if (lvl && ramp_run_o !== 1'b1) pos_bad = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    mode_i = 2'b01; trig_i = 1'b0; arm_i = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic pulse_arm();
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic count_high(input int win, output int highs);
    highs = 0;
    repeat (win) begin
      @(negedge clk);
      if (gate_o) highs++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, e, h, effl, effh;
    bit pb;
    rst_n = 1'b0; mode_i = 2'b01; trig_i = 1'b0; arm_i = 1'b0;
    holdoff_len_i = 8'd2; sweep_len_i = 8'd3;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(gate_o === 1'b0 && ramp_run_o === 1'b0 && sweep_end_o === 1'b0,
          "R1 outputs in reset", int'(gate_o), 0);
    check(not_trig_o === 1'b1 && ramp_pos_o === '0, "R1 flag in reset", int'(not_trig_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 after release, no trigger yet
    check(gate_o === 1'b0 && ramp_pos_o === '0, "R1 after release", int'(gate_o), 0);
    check(not_trig_o === 1'b1, "R1 flag after release", int'(not_trig_o), 1);

    // R4: single mode with no arm since reset
    idle();
    mode_i = 2'b10;
    pulse_trig();
    count_high(20, h);
    check(h == 0, "R4 unarmed trigger ignored", h, 0);
    pulse_arm();
    count_high(5, h);
    check(h == 0, "R4 arm alone starts nothing", h, 0);
    pulse_trig();
    check(gate_o === 1'b1, "R4 armed trigger starts sweep", int'(gate_o), 1);
    run_len(1'b1, n, e, pb);
    repeat (10) @(negedge clk);
    pulse_trig();
    count_high(20, h);
    check(h == 0, "R4 second trigger without re-arm ignored", h, 0);
    pulse_arm();
    pulse_trig();
    check(gate_o === 1'b1, "R4 re-arm allows one more sweep", int'(gate_o), 1);

    // Vector table: R2 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      idle();
      sweep_len_i   = VEC[i][15:8];
      holdoff_len_i = VEC[i][7:0];
      effl = (VEC[i][15:8] == 0) ? 1 : int'(VEC[i][15:8]);
      effh = (VEC[i][7:0] == 0) ? 1 : int'(VEC[i][7:0]);
      mode_i = VEC[i][17:16];
      pulse_trig();
      check(gate_o === 1'b1, "R2 R10 trigger starts sweep next edge", int'(gate_o), 1);
      check(not_trig_o === 1'b0, "R9 triggered start clears flag", int'(not_trig_o), 0);
      run_len(1'b1, n, e, pb);
      check(n == effl, "R5 gate width", n, effl);
      check(!pb, "R5 ramp position sequence", int'(pb), 0);
      check(e == 1, "R6 one end strobe per sweep", e, 1);
      trig_i = 1'b1;
      run_len(1'b0, n, e, pb);
      trig_i = 1'b0;
      check(n == effh + 1, "R7 hold-off gap with trigger held", n, effh + 1);
    end

    // R10: code 2'b11 never free-runs
    idle();
    mode_i = 2'b11;
    count_high(60, h);
    check(h == 0, "R10 mode 11 has no auto start", h, 0);

    // R2 and R9: normal mode with no trigger
    idle();
    count_high(60, h);
    check(h == 0, "R2 no sweep without trigger", h, 0);
    check(not_trig_o === 1'b1, "R9 timeout sets flag in normal mode", int'(not_trig_o), 1);

    // R3: auto free-run and early trigger
    sweep_len_i = 8'd3; holdoff_len_i = 8'd2;
    mode_i = 2'b00; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    check(gate_o === 1'b1 && not_trig_o === 1'b0, "R9 auto triggered start clears flag",
          int'(not_trig_o), 0);
    run_len(1'b1, n, e, pb);
    run_len(1'b0, n, e, pb);
    check(n == 2 + AW, "R3 free-run after timeout", n, 2 + AW);
    check(not_trig_o === 1'b1, "R9 free-run sets flag", int'(not_trig_o), 1);
    run_len(1'b1, n, e, pb);
    repeat (3) @(negedge clk);
    pulse_trig();
    check(gate_o === 1'b1, "R3 trigger during wait starts early", int'(gate_o), 1);

    // R8: triggers in sweep and hold-off are dropped
    idle();
    sweep_len_i = 8'd6; holdoff_len_i = 8'd4;
    pulse_trig();
    @(negedge clk);
    pulse_trig();
    run_len(1'b1, n, e, pb);
    check(n == 4, "R8 trigger in sweep leaves width", n, 4);
    @(negedge clk);
    pulse_trig();
    count_high(40, h);
    check(h == 0, "R8 no queued sweep", h, 0);

    finish_run();
  end

endmodule